// File: doc/BRIEF.md
# Two-Wire Serial Memory Slave Engine

This block is the bus side of a 256-byte serial memory that answers on a two-wire bus. A fast system clock samples the clock and data lines through synchronisers. The block finds start and stop conditions, shifts in a header byte, a word address and data bytes, and drives an active-high pull-low enable for the data line. That enable is used both for acknowledges and for read data. It keeps an 8-bit byte address counter. It supports current-address, random and sequential reads from a simple read port into the storage array.

Bytes written by the host go out as one-cycle pulses to a separate write engine, together with a flag that marks whether the target is the array or a one-time protection register. The engine may refuse a byte through a nack request. While the engine reports busy, the block stays silent to every header, so a host can poll for acknowledge.

Top module: `twm_mem_slave`

## Requirements
- R1: After reset the data-line pull enable is low, no write pulse is issued and the read address is 0x00.
- R2: A start condition seen in any state, including partway through a byte, abandons the transfer and begins reception of a new header byte.
- R3: Header bits [7:4] are the type code, bits [3:1] are compared with `dev_sel_i`, and bit [0] is the direction (1 = read). A wrong type code or a mismatched select gets no acknowledge, and the bus is then ignored until the next start or stop.
- R4: For an array write (type 1010, bit0 = 0), the block acknowledges the header, acknowledges the word address and loads it into the counter. It acknowledges each data byte and presents it as a one-cycle `wr_valid_o` with `wr_prot_o` = 0, the counter value as the address, and the byte as the data.
- R5: After each accepted array data byte, only the low PAGE_W bits of the counter increment, so writes wrap inside a page of 2^PAGE_W bytes.
- R6: An array read header (type 1010, bit0 = 1) sent without a preceding word address returns the byte at the counter. The counter then points one past that byte.
- R7: A write header and word address, followed by a repeated start and a read header, returns the byte at that word address.
- R8: During a read, each master acknowledge brings the next byte. The counter steps over all 8 bits, so 0xFF is followed by 0x00.
- R9: While `wr_busy_i` is high, no header of either type code is acknowledged.
- R10: A protection-register write (type 0110, bit0 = 0) acknowledges the header and both following bytes, whatever their values. It pulses `wr_valid_o` with `wr_prot_o` = 1 and leaves the counter unchanged. A read header with type 0110 is not acknowledged.
- R11: If `wr_nack_i` is high when a data byte completes, that byte gets no acknowledge, no write pulse and no counter step.
- R12: A master non-acknowledge ends read output, after which the data line stays released. A stop returns the block to idle, and in idle clock pulses without a start are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than the bus clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Bus clock line as seen at the pad |
| sda_i | input | 1 | Bus data line as seen at the pad |
| dev_sel_i | input | 3 | Device-select strap compared with header bits [3:1] |
| sda_pull_o | output | 1 | High pulls the data line low |
| rd_addr_o | output | 8 | Read address into the storage array (the counter) |
| rd_data_i | input | 8 | Byte read from the storage array at `rd_addr_o` |
| wr_valid_o | output | 1 | One-cycle pulse for an accepted write byte |
| wr_prot_o | output | 1 | Write target: 1 protection register, 0 array |
| wr_addr_o | output | 8 | Array address of the write byte |
| wr_data_o | output | 8 | Write byte |
| wr_busy_i | input | 1 | Write engine is in its internal write cycle |
| wr_nack_i | input | 1 | Write engine refuses the current data byte |

## Verification
The bench builds the block with its defaults: PAGE_W = 4 and two synchroniser stages. With a 16-byte page, a three-byte write from 0x1E is enough to show the page wrap to 0x10. Starting a sequential read at 0xFE shows the full 8-bit counter wrap in four bytes. With a short synchroniser chain, a bus half-period of ten system clocks leaves ample margin between a bus edge and the block's reaction to it.

// File: rtl/twm_pkg.sv
package twm_pkg;
    localparam int BYTE_W = 8;
    localparam logic [3:0] TYPE_ARRAY = 4'b1010;
    localparam logic [3:0] TYPE_PROT  = 4'b0110;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RECV,
        ST_ACK,
        ST_SEND,
        ST_MACK,
        ST_HOLD
    } state_e;

    typedef enum logic [1:0] {
        K_DEV,
        K_WORD,
        K_DATA
    } kind_e;
endpackage

// File: rtl/twm_line_sync.sv
module twm_line_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic sda_o,
    output logic scl_rise_o,
    output logic scl_fall_o,
    output logic start_o,
    output logic stop_o
);
    typedef struct packed {
        logic [STAGES-1:0] scl_sh;
        logic [STAGES-1:0] sda_sh;
        logic              scl_p;
        logic              sda_p;
    } sync_t;

    sync_t d, q;
    logic  scl_s, sda_s;

    assign scl_s = q.scl_sh[STAGES-1];
    assign sda_s = q.sda_sh[STAGES-1];

    always_comb begin
        d        = q;
        d.scl_sh = {q.scl_sh[STAGES-2:0], scl_i};
        d.sda_sh = {q.sda_sh[STAGES-2:0], sda_i};
        d.scl_p  = scl_s;
        d.sda_p  = sda_s;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '1;
        else        q <= d;
    end

    assign sda_o      = sda_s;
    assign scl_rise_o = scl_s & ~q.scl_p;
    assign scl_fall_o = ~scl_s & q.scl_p;
    assign start_o    = scl_s & q.scl_p & q.sda_p & ~sda_s;
    assign stop_o     = scl_s & q.scl_p & ~q.sda_p & sda_s;
endmodule

// File: rtl/twm_bus_fsm.sv
module twm_bus_fsm
    import twm_pkg::*;
#(
    parameter int PAGE_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sda_i,
    input  logic              scl_rise_i,
    input  logic              scl_fall_i,
    input  logic              start_i,
    input  logic              stop_i,
    input  logic [2:0]        dev_sel_i,
    input  logic [BYTE_W-1:0] rd_data_i,
    input  logic              wr_busy_i,
    input  logic              wr_nack_i,
    output logic              sda_pull_o,
    output logic [BYTE_W-1:0] rd_addr_o,
    output logic              wr_valid_o,
    output logic              wr_prot_o,
    output logic [BYTE_W-1:0] wr_addr_o,
    output logic [BYTE_W-1:0] wr_data_o
);
    localparam logic [3:0] BITS_FULL = 4'(BYTE_W);

    typedef struct packed {
        state_e            state;
        kind_e             kind;
        logic [3:0]        bitcnt;
        logic [BYTE_W-1:0] shreg;
        logic [BYTE_W-1:0] addr;
        logic              rd;
        logic              prot;
        logic              oe;
        logic              mack;
        logic              wvld;
        logic [BYTE_W-1:0] waddr;
        logic [BYTE_W-1:0] wdata;
    } fsm_t;

    fsm_t              d, q;
    logic [PAGE_W-1:0] pg;
    logic              hit_sel, is_arr, is_prot, take;

    always_comb begin
        d       = q;
        d.wvld  = 1'b0;
        pg      = q.addr[PAGE_W-1:0] + 1'b1;
        hit_sel = (q.shreg[3:1] == dev_sel_i);
        is_arr  = (q.shreg[7:4] == TYPE_ARRAY);
        is_prot = (q.shreg[7:4] == TYPE_PROT);
        take    = 1'b0;
        if (start_i) begin
            d.state  = ST_RECV;
            d.kind   = K_DEV;
            d.bitcnt = '0;
            d.oe     = 1'b0;
        end else if (stop_i) begin
            d.state = ST_IDLE;
            d.oe    = 1'b0;
        end else begin
            case (q.state)
                ST_RECV: begin
                    if (scl_rise_i && q.bitcnt != BITS_FULL) begin
                        d.shreg  = {q.shreg[BYTE_W-2:0], sda_i};
                        d.bitcnt = q.bitcnt + 4'd1;
                    end else if (scl_fall_i && q.bitcnt == BITS_FULL) begin
                        case (q.kind)
                            K_DEV: begin
                                d.rd   = q.shreg[0];
                                d.prot = is_prot;
                                take   = hit_sel && !wr_busy_i &&
                                         (is_arr || (is_prot && !q.shreg[0]));
                            end
                            K_WORD: begin
                                take = 1'b1;
                                if (!q.prot) d.addr = q.shreg;
                            end
                            default: begin
                                take = !wr_nack_i;
                                if (take) begin
                                    d.wvld  = 1'b1;
                                    d.waddr = q.addr;
                                    d.wdata = q.shreg;
                                    if (!q.prot) d.addr = {q.addr[BYTE_W-1:PAGE_W], pg};
                                end
                            end
                        endcase
                        d.state = take ? ST_ACK : ST_HOLD;
                        d.oe    = take;
                    end
                end
                ST_ACK: begin
                    if (scl_fall_i) begin
                        d.oe     = 1'b0;
                        d.bitcnt = '0;
                        if (q.kind == K_DEV && q.rd) begin
                            d.state  = ST_SEND;
                            d.shreg  = rd_data_i;
                            d.oe     = ~rd_data_i[BYTE_W-1];
                            d.bitcnt = 4'd1;
                            d.addr   = q.addr + 1'b1;
                        end else begin
                            d.state = ST_RECV;
                            d.kind  = (q.kind == K_DEV) ? K_WORD : K_DATA;
                        end
                    end
                end
                ST_SEND: begin
                    if (scl_fall_i) begin
                        if (q.bitcnt == BITS_FULL) begin
                            d.oe    = 1'b0;
                            d.state = ST_MACK;
                            d.mack  = 1'b0;
                        end else begin
                            d.shreg  = {q.shreg[BYTE_W-2:0], 1'b0};
                            d.oe     = ~q.shreg[BYTE_W-2];
                            d.bitcnt = q.bitcnt + 4'd1;
                        end
                    end
                end
                ST_MACK: begin
                    if (scl_rise_i) begin
                        d.mack = ~sda_i;
                    end else if (scl_fall_i) begin
                        if (q.mack) begin
                            d.state  = ST_SEND;
                            d.shreg  = rd_data_i;
                            d.oe     = ~rd_data_i[BYTE_W-1];
                            d.bitcnt = 4'd1;
                            d.addr   = q.addr + 1'b1;
                        end else begin
                            d.state = ST_HOLD;
                        end
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q       <= '0;
            q.state <= ST_IDLE;
            q.kind  <= K_DEV;
        end else begin
            q <= d;
        end
    end

    assign sda_pull_o = q.oe;
    assign rd_addr_o  = q.addr;
    assign wr_valid_o = q.wvld;
    assign wr_prot_o  = q.prot;
    assign wr_addr_o  = q.waddr;
    assign wr_data_o  = q.wdata;

    // R2: a start always restarts header reception
    p_restart_r2: assert property (@(posedge clk) disable iff (!rst_n)
        start_i |=> (q.state == ST_RECV && q.kind == K_DEV && q.bitcnt == 4'd0));

    // R12: a stop leaves the block idle with the line released
    p_stop_idle_r12: assert property (@(posedge clk) disable iff (!rst_n)
        stop_i |=> (q.state == ST_IDLE && !q.oe));

    // R9: a header completing while the engine is busy is never acknowledged
    p_busy_silent_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (q.state == ST_RECV && q.kind == K_DEV && q.bitcnt == BITS_FULL &&
         scl_fall_i && wr_busy_i) |=> !q.oe);

    // R11: a refused data byte yields neither acknowledge nor write pulse
    p_nack_req_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (q.state == ST_RECV && q.kind == K_DATA && q.bitcnt == BITS_FULL &&
         scl_fall_i && wr_nack_i) |=> (!q.oe && !q.wvld));

    // R4: each accepted byte gives a single-cycle pulse
    p_write_pulse_r4: assert property (@(posedge clk) disable iff (!rst_n)
        q.wvld |=> !q.wvld);
endmodule

// File: rtl/twm_mem_slave.sv
module twm_mem_slave
    import twm_pkg::*;
#(
    parameter int PAGE_W      = 4,
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       scl_i,
    input  logic       sda_i,
    input  logic [2:0] dev_sel_i,
    output logic       sda_pull_o,
    output logic [7:0] rd_addr_o,
    input  logic [7:0] rd_data_i,
    output logic       wr_valid_o,
    output logic       wr_prot_o,
    output logic [7:0] wr_addr_o,
    output logic [7:0] wr_data_o,
    input  logic       wr_busy_i,
    input  logic       wr_nack_i
);
    logic sda_s, scl_rise, scl_fall, start_c, stop_c;

    twm_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk        (clk),
        .rst_n      (rst_n),
        .scl_i      (scl_i),
        .sda_i      (sda_i),
        .sda_o      (sda_s),
        .scl_rise_o (scl_rise),
        .scl_fall_o (scl_fall),
        .start_o    (start_c),
        .stop_o     (stop_c)
    );

    twm_bus_fsm #(.PAGE_W(PAGE_W)) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .sda_i      (sda_s),
        .scl_rise_i (scl_rise),
        .scl_fall_i (scl_fall),
        .start_i    (start_c),
        .stop_i     (stop_c),
        .dev_sel_i  (dev_sel_i),
        .rd_data_i  (rd_data_i),
        .wr_busy_i  (wr_busy_i),
        .wr_nack_i  (wr_nack_i),
        .sda_pull_o (sda_pull_o),
        .rd_addr_o  (rd_addr_o),
        .wr_valid_o (wr_valid_o),
        .wr_prot_o  (wr_prot_o),
        .wr_addr_o  (wr_addr_o),
        .wr_data_o  (wr_data_o)
    );
endmodule

// File: tb/tb_twm_mem_slave.sv
module tb_twm_mem_slave;
    localparam int H = 10;
    localparam logic [2:0] SEL = 3'b101;

    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic       rst_n = 1'b0;
    logic       scl = 1'b1, sda_m = 1'b1;
    logic       sda_pull, wr_valid, wr_prot, wr_busy = 1'b0, wr_nack = 1'b0;
    logic [7:0] rd_addr, rd_data, wr_addr, wr_data;
    logic       sda_line;
    assign sda_line = sda_m & ~sda_pull;

    logic [7:0]  ram [256];
    logic [7:0]  exp_mem [256];
    logic [16:0] wq [$];
    int          errs = 0, checks = 0, ptr = 0, quiet_bad = 0;
    logic        quiet_win = 1'b0;
    bit          a;
    logic [7:0]  b;

    assign rd_data = ram[rd_addr];

    twm_mem_slave dut (
        .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda_line), .dev_sel_i(SEL),
        .sda_pull_o(sda_pull), .rd_addr_o(rd_addr), .rd_data_i(rd_data),
        .wr_valid_o(wr_valid), .wr_prot_o(wr_prot), .wr_addr_o(wr_addr),
        .wr_data_o(wr_data), .wr_busy_i(wr_busy), .wr_nack_i(wr_nack)
    );

    // write engine and array model
    always @(negedge clk) begin
        if (wr_valid) begin
            wq.push_back({wr_prot, wr_addr, wr_data});
            if (!wr_prot) ram[wr_addr] <= wr_data;
        end
        if (quiet_win && sda_pull) quiet_bad++;
    end

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errs++;
            $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
        end
    endtask

    task automatic chk_wr(input string tag, input bit p, input logic [7:0] ad, input logic [7:0] da);
        logic [16:0] e;
        if (wq.size() == 0) begin
            checks++; errs++;
            $display("FAIL %s act=none exp=%0h", tag, {p, ad, da});
        end else begin
            e = wq.pop_front();
            if (p) chk(tag, int'(e[16]), 1);
            else   chk(tag, int'(e), int'({p, ad, da}));
        end
    endtask

    task automatic w(input int n); repeat (n) @(negedge clk); endtask

    task automatic bus_start;
        sda_m = 1'b1; w(H); scl = 1'b1; w(H); sda_m = 1'b0; w(H); scl = 1'b0; w(H);
    endtask

    task automatic bus_stop;
        sda_m = 1'b0; w(H); scl = 1'b1; w(H); sda_m = 1'b1; w(H);
    endtask

    task automatic clk_bit(input bit v, output bit s);
        sda_m = v; w(H); scl = 1'b1; w(H/2); s = sda_line; w(H/2); scl = 1'b0;
    endtask

    task automatic send(input logic [7:0] v, output bit ack);
        bit s;
        for (int i = 7; i >= 0; i--) clk_bit(v[i], s);
        clk_bit(1'b1, s);
        ack = ~s;
        sda_m = 1'b1;
    endtask

    task automatic recv(input bit mack, output logic [7:0] v);
        bit s;
        for (int i = 7; i >= 0; i--) begin clk_bit(1'b1, s); v[i] = s; end
        clk_bit(~mack, s);
        sda_m = 1'b1;
    endtask

    function automatic logic [7:0] hdr(input logic [3:0] t, input logic [2:0] sl, input bit r);
        return {t, sl, r};
    endfunction

    initial begin
        repeat (150000) @(posedge clk);
        checks++; errs++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end

    initial begin
        for (int i = 0; i < 256; i++) begin
            ram[i] = 8'(i) ^ 8'h5A;
            exp_mem[i] = 8'(i) ^ 8'h5A;
        end
        w(5); rst_n = 1'b1; w(5);
        // R1 reset state
        chk("R1 pull after reset", sda_pull, 0);
        chk("R1 write pulse after reset", wr_valid, 0);
        chk("R1 counter after reset", rd_addr, 0);

        // R4 byte write
        bus_start;
        send(hdr(4'b1010, SEL, 0), a); chk("R4 array write header ack", a, 1);
        send(8'h40, a); chk("R4 word ack", a, 1);
        send(8'hC3, a); chk("R4 data ack", a, 1);
        bus_stop; w(4);
        chk_wr("R4 write byte", 0, 8'h40, 8'hC3);
        exp_mem[8'h40] = 8'hC3; ptr = 8'h41;

        // R3 header decode
        bus_start;
        send(hdr(4'b1010, 3'b011, 0), a); chk("R3 select mismatch nack", a, 0);
        send(8'h10, a); chk("R3 ignored after mismatch", a, 0);
        bus_stop;
        bus_start;
        send(hdr(4'b1011, SEL, 1), a); chk("R3 wrong type nack", a, 0);
        bus_stop; w(4);
        chk("R3 no write pulses", wq.size(), 0);

        // R5 page wrap
        bus_start;
        send(hdr(4'b1010, SEL, 0), a);
        send(8'h1E, a);
        send(8'h11, a); send(8'h22, a); send(8'h33, a);
        chk("R5 third byte ack", a, 1);
        bus_stop; w(4);
        chk_wr("R5 page byte0", 0, 8'h1E, 8'h11);
        chk_wr("R5 page byte1", 0, 8'h1F, 8'h22);
        chk_wr("R5 page wrap", 0, 8'h10, 8'h33);
        exp_mem[8'h1E] = 8'h11; exp_mem[8'h1F] = 8'h22; exp_mem[8'h10] = 8'h33; ptr = 8'h11;

        // R6 current address read
        bus_start;
        send(hdr(4'b1010, SEL, 1), a); chk("R6 read header ack", a, 1);
        recv(0, b); chk("R6 current read data", b, exp_mem[ptr]);
        bus_stop; ptr = (ptr + 1) % 256;

        // R7 random read
        bus_start;
        send(hdr(4'b1010, SEL, 0), a); send(8'h40, a);
        bus_start;
        send(hdr(4'b1010, SEL, 1), a); chk("R7 repeated start header ack", a, 1);
        recv(0, b); chk("R7 random read data", b, exp_mem[8'h40]);
        bus_stop;

        // R8 sequential read with wrap, R12 nack ends output
        bus_start;
        send(hdr(4'b1010, SEL, 0), a); send(8'hFE, a);
        bus_start;
        send(hdr(4'b1010, SEL, 1), a);
        recv(1, b); chk("R8 seq byte FE", b, exp_mem[8'hFE]);
        recv(1, b); chk("R8 seq byte FF", b, exp_mem[8'hFF]);
        recv(1, b); chk("R8 seq wrap 00", b, exp_mem[8'h00]);
        recv(0, b); chk("R8 seq byte 01", b, exp_mem[8'h01]);
        quiet_win = 1'b1;
        for (int i = 0; i < 9; i++) clk_bit(1'b1, a);
        bus_stop;
        for (int i = 0; i < 9; i++) clk_bit(1'b1, a);
        w(4); quiet_win = 1'b0;
        chk("R12 line released after nack and in idle", quiet_bad, 0);
        ptr = 8'h02;

        // R9 busy polling
        wr_busy = 1'b1;
        bus_start;
        send(hdr(4'b1010, SEL, 0), a); chk("R9 busy array nack", a, 0);
        bus_start;
        send(hdr(4'b0110, SEL, 0), a); chk("R9 busy protect nack", a, 0);
        bus_stop; wr_busy = 1'b0;
        bus_start;
        send(hdr(4'b1010, SEL, 0), a); chk("R9 ack after busy clears", a, 1);
        bus_stop;

        // R10 protection register
        bus_start;
        send(hdr(4'b0110, SEL, 0), a); chk("R10 protect header ack", a, 1);
        send(8'hA7, a); chk("R10 dont-care word ack", a, 1);
        send(8'h3C, a); chk("R10 dont-care data ack", a, 1);
        bus_stop; w(4);
        chk_wr("R10 protect write flag", 1, 8'h00, 8'h00);
        bus_start;
        send(hdr(4'b0110, SEL, 1), a); chk("R10 protect read nack", a, 0);
        bus_stop;
        bus_start;
        send(hdr(4'b1010, SEL, 1), a);
        recv(0, b); chk("R10 counter unchanged", b, exp_mem[ptr]);
        bus_stop; ptr = (ptr + 1) % 256;

        // R11 engine refusal
        wr_nack = 1'b1;
        bus_start;
        send(hdr(4'b1010, SEL, 0), a); send(8'h30, a);
        send(8'h99, a); chk("R11 refused data nack", a, 0);
        bus_stop; wr_nack = 1'b0; w(4);
        chk("R11 no write pulse", wq.size(), 0);
        bus_start;
        send(hdr(4'b1010, SEL, 1), a);
        recv(0, b); chk("R11 counter not stepped", b, exp_mem[8'h30]);
        bus_stop; ptr = 8'h31;

        // R2 start mid-byte
        bus_start;
        for (int i = 0; i < 3; i++) clk_bit(1'b1, a);
        bus_start;
        send(hdr(4'b1010, SEL, 1), a); chk("R2 restart header ack", a, 1);
        recv(0, b); chk("R2 restart read data", b, exp_mem[ptr]);
        bus_stop; w(4);

        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end
endmodule